// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor with End-Around Carry

This block adds or subtracts two N-bit signed integers held in ones-complement form. The result is formed in the same cycle, with no clock. When the subtract select is high, the second operand is negated by flipping all of its bits before the sum is taken. The carry that leaves the top bit of that first sum is not dropped. It is fed back and added into the lowest bit, which keeps the result in ones-complement form.

The block has two status outputs. One raises when the true result cannot be held in N bits. The other raises when the result is the all-ones pattern, which is the second code for zero. The block does not rewrite that code to all zeros. Any consumer that needs a single zero code does that itself.

Top module: `ones_eac_addsub`

## Requirements
- R1: The top bit is the sign. A code whose top bit is 0 stands for its unsigned value. A code whose top bit is 1 stands for minus (2^N − 1 − code). For example, with N=5, 10110 is −9 and 01011 is +11.
- R2: With `sub_sel`=0, `result` encodes `a_in` + `b_in` whenever that sum lies in [−(2^(N−1)−1), 2^(N−1)−1].
- R3: With `sub_sel`=1, the second operand is the bitwise inverse of `b_in`. When in range, `result` encodes `a_in` − `b_in`.
- R4: A carry out of the top bit of the first sum is added into the lowest bit. For example, 11010 + 11011 with N=5 gives 10110.
- R5: With no carry out of the top bit, the first sum is the result. For example, 11010 + 00100 with N=5 gives 11110.
- R6: `overflow` is 1 exactly when both effective operands have the same sign bit and the result sign differs from it. This is the same as the true result lying outside the range in R2.
- R7: `neg_zero` is 1 exactly when `result` is all ones.
- R8: Both zero codes (all zeros and all ones) act as zero when used as operands. For example, 11111 + 00000 gives 11111, and 00000 + 00000 gives 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | First operand, ones-complement |
| b_in | input | N | Second operand, ones-complement |
| sub_sel | input | 1 | 1 = subtract b_in, 0 = add |
| result | output | N | Ones-complement sum or difference |
| overflow | output | 1 | True result out of representable range |
| neg_zero | output | 1 | Result is the all-ones zero code |

## Verification
Four properties are checked every time the inputs change:
- The negation step flips every bit of the second operand when subtracting, and none when adding.
- The fold pass never produces a carry of its own.
- Every result without overflow has the integer value of the operands' sum.
- The overflow flag and the negative-zero flag agree with integer arithmetic on the operands.

Only the bench's scenarios can show the exact bit pattern chosen in each case. This covers which zero code a zero sum produces, the wrapped code after an overflow, and the specific worked cases with and without an end-around carry. To do so, the bench sweeps every operand pair in both modes.

// File: rtl/ones_pkg.sv
package ones_pkg;
  localparam int unsigned MAX_W = 32;

  // Integer value of an ones-complement code of the given width.
  function automatic int ones_value(input logic [MAX_W-1:0] code, input int width);
    logic [MAX_W-1:0] mask;
    mask = (width >= MAX_W) ? '1 : ((MAX_W'(1) << width) - MAX_W'(1));
    if (code[width-1]) return -int'((~code) & mask);
    else               return int'(code & mask);
  endfunction
endpackage

// File: rtl/ones_operand_cond.sv
module ones_operand_cond #(
  parameter int N = 5
) (
  input  logic [N-1:0] b_in,
  input  logic         sub_sel,
  output logic [N-1:0] b_eff
);
  for (genvar i = 0; i < N; i++) begin : g_flip
    assign b_eff[i] = b_in[i] ^ sub_sel;
  end

  always_comb begin
    // R3
    negate_chk: assert ($countones(b_eff ^ b_in) == (sub_sel ? N : 0))
      else $error("negation step wrong");
  end
endmodule

// File: rtl/ones_ripple.sv
module ones_ripple #(
  parameter int N = 5
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_fa
    logic half;
    assign half       = x[i] ^ y[i];
    assign sum[i]     = half ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (half & carry[i]);
  end

  assign cout = carry[N];
endmodule

// File: rtl/ones_flags.sv
module ones_flags #(
  parameter int N = 5
) (
  input  logic         a_sign,
  input  logic         b_sign,
  input  logic [N-1:0] res,
  output logic         overflow,
  output logic         neg_zero
);
  assign overflow = (a_sign == b_sign) && (res[N-1] != a_sign);
  assign neg_zero = &res;
endmodule

// File: rtl/ones_eac_addsub.sv
module ones_eac_addsub
  import ones_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         sub_sel,
  output logic [N-1:0] result,
  output logic         overflow,
  output logic         neg_zero
);
  localparam int HI = (1 << (N - 1)) - 1;

  logic [N-1:0] b_eff;
  logic [N-1:0] first_sum;
  logic         first_carry;
  logic         fold_carry;

  ones_operand_cond #(.N(N)) u_cond (
    .b_in(b_in), .sub_sel(sub_sel), .b_eff(b_eff)
  );

  ones_ripple #(.N(N)) u_main (
    .x(a_in), .y(b_eff), .cin(1'b0), .sum(first_sum), .cout(first_carry)
  );

  // End-around carry: fold the top carry back into bit 0.
  ones_ripple #(.N(N)) u_fold (
    .x(first_sum), .y('0), .cin(first_carry), .sum(result), .cout(fold_carry)
  );

  ones_flags #(.N(N)) u_flags (
    .a_sign(a_in[N-1]), .b_sign(b_eff[N-1]), .res(result),
    .overflow(overflow), .neg_zero(neg_zero)
  );

  int true_sum;
  always_comb begin
    true_sum = ones_value(MAX_W'(a_in), N) + ones_value(MAX_W'(b_eff), N);
    // R4
    eac_nocarry_chk: assert (!fold_carry)
      else $error("fold pass carried out");
    // R2
    sum_value_chk: assert (overflow || ones_value(MAX_W'(result), N) == true_sum)
      else $error("result value differs from integer sum");
    // R6
    ovf_range_chk: assert (overflow == (true_sum > HI || true_sum < -HI))
      else $error("overflow flag disagrees with range");
    // R7
    negzero_chk: assert (!neg_zero || (!overflow && true_sum == 0))
      else $error("negative zero without a zero sum");
  end
endmodule

// File: tb/tb_ones_eac_addsub.sv
`timescale 1ns/1ps
module tb_ones_eac_addsub;
  localparam int N    = 5;
  localparam int FULL = (1 << N) - 1;
  localparam int HI   = (1 << (N - 1)) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] a_in, b_in, result;
  logic         sub_sel, overflow, neg_zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  ones_eac_addsub #(.N(N)) dut (
    .a_in(a_in), .b_in(b_in), .sub_sel(sub_sel),
    .result(result), .overflow(overflow), .neg_zero(neg_zero)
  );

  function automatic int val_of(input int code);
    if (code >= (1 << (N - 1))) return -(FULL - code);
    return code;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Apply one vector after a rising edge and compare at the falling edge.
  task automatic run_vec(input int a, input int b, input bit s);
    int beff, raw, tru;
    @(posedge clk);
    #1;
    a_in = N'(a); b_in = N'(b); sub_sel = s;
    beff = s ? (FULL - b) : b;
    raw  = a + beff;
    if (raw > FULL) raw = raw - FULL;          // end-around carry
    tru  = val_of(a) + (s ? -val_of(b) : val_of(b));
    @(negedge clk);
    check(s ? "R3 result bits" : "R2 result bits", int'(result), raw);
    check("R6 overflow", int'(overflow), int'(tru > HI || tru < -HI));
    check("R7 neg_zero", int'(neg_zero), int'(raw == FULL));
    if (!(tru > HI || tru < -HI))
      check("R1 decoded value", val_of(int'(result)), tru);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; a_in = '0; b_in = '0; sub_sel = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset state result", int'(result), 0);
    check("R7 reset state neg_zero", int'(neg_zero), 0);

    // R4: carry folded back, 11010 + 11011 -> 10110 (-9)
    run_vec(5'b11010, 5'b11011, 1'b0);
    check("R4 example", int'(result), 5'b10110);
    // R1: 01100 + 11110 -> 01011 (+11)
    run_vec(5'b01100, 5'b11110, 1'b0);
    check("R1 example value", val_of(int'(result)), 11);
    // R5: no carry, 11010 + 00100 -> 11110
    run_vec(5'b11010, 5'b00100, 1'b0);
    check("R5 example", int'(result), 5'b11110);
    // R3: 01100 - 00001 -> 01011
    run_vec(5'b01100, 5'b00001, 1'b1);
    check("R3 example", int'(result), 5'b01011);
    // R8: negative zero operand
    run_vec(5'b11111, 5'b00000, 1'b0);
    check("R8 neg zero operand", int'(result), 5'b11111);
    run_vec(5'b00000, 5'b00000, 1'b0);
    check("R8 pos zero operands", int'(result), 5'b00000);
    // R6: +15 + +15 overflows
    run_vec(5'b01111, 5'b01111, 1'b0);
    check("R6 example", int'(overflow), 1);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a <= FULL; a++)
        for (int b = 0; b <= FULL; b++)
          run_vec(a, b, s[0]);

    finish_run();
  end
endmodule